// File: doc/BRIEF.md
# Octal Output Fault Latch Controller

This block sits between the committed command byte of a low-side switch array and the drivers themselves. For each of eight channels it decides whether the driver may be on. A fault reported by the sense logic shuts the channel down and holds it off until software clears it on purpose. Current limiting, thermal sensing and saturation sensing happen elsewhere and arrive here only as one-bit flags per channel. The latched faults are presented as a status word that a serial front end shifts back to the host.

Channels fall into two classes. General channels latch on an over-current flag. Lamp channels latch on either a current-limit flag or a thermal flag. Any channel can also latch a desaturation fault. The desaturation latch alone can be released while the chip-select line is low. The command path keeps working through a fault. A channel recovers only when its command bit goes low and then high again, or, for the two designated channels, through reset. The reset pin and the low-supply flag each force every driver off.

Top module: `ofl_ctrl`

## Requirements
- R1: A channel in the general class (default channels 0 to 5) latches its fault on the over-current flag `ocur_i[n]`. Its thermal flag `therm_i[n]` has no effect on it.
- R2: A channel in the lamp class (default channels 6 and 7) latches its fault on `ocur_i[n]` (used as the current-limit flag) or on `therm_i[n]`.
- R3: Outside reset, `drv_en_o[n]` is 1 exactly when `cmd_i[n]` is 1 and `flt_stat_o[n]` is 0.
- R4: A latched fault persists while the command bit stays high, and also while it stays low. The fault clears on the clock edge at which `cmd_i[n]` is high after having been low on the previous edge. The cleared status is visible after that edge.
- R5: If a fault flag is still present on the edge that would clear the latch, the latch stays set.
- R6: While `rst_pin_n` is 0, every bit of `drv_en_o` is 0 in the same cycle, whatever the command.
- R7: Each clock edge during reset clears the fault latches of channels 1 and 2 only. The latches of the other channels are kept. A fault flag present on such an edge still sets the latch.
- R8: `lv_det_i` at 1 alone produces the same behaviour as R6 and R7.
- R9: A desaturation flag `desat_i[n]` latches a fault on any channel. Each edge with `ce_n_i` at 0 clears that latch, unless the flag is still present. An over-current or thermal latch is not cleared by `ce_n_i`.
- R10: With `arst_n` at 0, all fault latches are cleared at once.
- R11: `flt_stat_o[n]` reports channel n, with 1 meaning a latched fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous power-on clear, active low |
| cmd_i | input | N_CH | Committed command byte, bit n turns channel n on |
| ocur_i | input | N_CH | Over-current / current-limit flag per channel |
| therm_i | input | N_CH | Thermal flag per channel (lamp class only) |
| desat_i | input | N_CH | Desaturation flag per channel |
| ce_n_i | input | 1 | Chip-select, low arms the desaturation unlatch |
| rst_pin_n | input | 1 | Functional reset pin, active low |
| lv_det_i | input | 1 | Low-supply detect, active high |
| drv_en_o | output | N_CH | Gated driver enables |
| flt_stat_o | output | N_CH | Latched fault status, bit n for channel n |

## Verification
Two functions can meet on one clock edge: a clear and a fault that is still present. The clear may come from a command rising edge, from reset on channels 1 and 2, or from chip-select on a desaturation latch. The bench provokes each pairing by holding the fault flag high across the clearing edge. It then checks that the status bit is still set after that edge, and that a second clear, once the flag drops, does release the channel. The bench also checks the combinational drive gating in the middle of the cycle, before the clock edge, so that it can tell an immediate shutdown apart from a registered one.

// File: rtl/ofl_pkg.sv
package ofl_pkg;

   localparam int unsigned OFL_MAX_CH = 32;

   // default channel classes for the eight-channel build
   localparam logic [7:0] OFL_GEN_MASK  = 8'b0011_1111;
   localparam logic [7:0] OFL_LAMP_MASK = 8'b1100_0000;
   localparam logic [7:0] OFL_RCLR_MASK = 8'b0000_0110;
   localparam logic [7:0] OFL_DSAT_MASK = 8'b1111_1111;

   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_HARD  = 2'd1,
      CH_DSAT  = 2'd2,
      CH_BOTH  = 2'd3
   } ofl_chan_state_e;

   function automatic logic any_fault(input ofl_chan_state_e st);
      return st != CH_IDLE;
   endfunction

endpackage

// File: rtl/ofl_rst_merge.sv
module ofl_rst_merge #(
   parameter bit UNLATCH_EN = 1'b1
) (
   input  logic rst_pin_n,
   input  logic lv_det_i,
   input  logic ce_n_i,
   output logic rst_act_o,
   output logic unlatch_o
);

   // either reset source alone gives the full reset behaviour
   assign rst_act_o = ~rst_pin_n | lv_det_i;

   generate
      if (UNLATCH_EN) begin : g_unl
         assign unlatch_o = ~ce_n_i;
      end else begin : g_nounl
         logic unused_ce;
         assign unused_ce = ce_n_i;
         assign unlatch_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ofl_cmd_edge.sv
module ofl_cmd_edge #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] cmd_i,
   output logic [W-1:0] rise_o
);

   logic [W-1:0] cmd_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) cmd_q <= '0;
      else         cmd_q <= cmd_i;
   end

   assign rise_o = cmd_i & ~cmd_q;

endmodule

// File: rtl/ofl_chan.sv
module ofl_chan
   import ofl_pkg::*;
#(
   parameter bit CLR_ON_RST = 1'b0
) (
   input  logic            clk,
   input  logic            arst_n,
   input  logic            hard_flt_i,
   input  logic            dsat_flt_i,
   input  logic            rise_i,
   input  logic            rst_act_i,
   input  logic            unlatch_i,
   output ofl_chan_state_e state_o
);

   logic hard_q, dsat_q;
   logic rst_clr;

   assign rst_clr = CLR_ON_RST & rst_act_i;

   // a flag present on the clearing edge wins
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                 hard_q <= 1'b0;
      else if (hard_flt_i)         hard_q <= 1'b1;
      else if (rise_i || rst_clr)  hard_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                             dsat_q <= 1'b0;
      else if (dsat_flt_i)                     dsat_q <= 1'b1;
      else if (rise_i || rst_clr || unlatch_i) dsat_q <= 1'b0;
   end

   assign state_o = ofl_chan_state_e'({dsat_q, hard_q});

endmodule

// File: rtl/ofl_ctrl.sv
module ofl_ctrl
   import ofl_pkg::*;
#(
   parameter int unsigned N_CH       = 8,
   parameter logic [N_CH-1:0] GEN_MASK  = N_CH'(OFL_GEN_MASK),
   parameter logic [N_CH-1:0] LAMP_MASK = N_CH'(OFL_LAMP_MASK),
   parameter logic [N_CH-1:0] RCLR_MASK = N_CH'(OFL_RCLR_MASK),
   parameter logic [N_CH-1:0] DSAT_MASK = N_CH'(OFL_DSAT_MASK),
   parameter bit UNLATCH_EN = 1'b1
) (
   input  logic            clk,
   input  logic            arst_n,
   input  logic [N_CH-1:0] cmd_i,
   input  logic [N_CH-1:0] ocur_i,
   input  logic [N_CH-1:0] therm_i,
   input  logic [N_CH-1:0] desat_i,
   input  logic            ce_n_i,
   input  logic            rst_pin_n,
   input  logic            lv_det_i,
   output logic [N_CH-1:0] drv_en_o,
   output logic [N_CH-1:0] flt_stat_o
);

   localparam logic [N_CH-1:0] CUR_MASK = GEN_MASK | LAMP_MASK;

   // elaboration-time parameter checks
   generate
      if (N_CH < 1 || N_CH > OFL_MAX_CH) begin : g_bad_n
         $error("ofl_ctrl: N_CH out of range");
      end
      if ((GEN_MASK & LAMP_MASK) != '0) begin : g_bad_cls
         $error("ofl_ctrl: a channel is in both classes");
      end
   endgenerate

   logic            rst_act, unlatch;
   logic [N_CH-1:0] rise, hard_flt, dsat_flt;
   ofl_chan_state_e st [N_CH];

   ofl_rst_merge #(.UNLATCH_EN(UNLATCH_EN)) u_rst (
      .rst_pin_n (rst_pin_n),
      .lv_det_i  (lv_det_i),
      .ce_n_i    (ce_n_i),
      .rst_act_o (rst_act),
      .unlatch_o (unlatch)
   );

   ofl_cmd_edge #(.W(N_CH)) u_edge (
      .clk    (clk),
      .arst_n (arst_n),
      .cmd_i  (cmd_i),
      .rise_o (rise)
   );

   generate
      for (genvar g = 0; g < N_CH; g++) begin : g_ch
         assign hard_flt[g] = (ocur_i[g] & CUR_MASK[g]) | (therm_i[g] & LAMP_MASK[g]);
         assign dsat_flt[g] = desat_i[g] & DSAT_MASK[g];

         ofl_chan #(.CLR_ON_RST(RCLR_MASK[g])) u_ch (
            .clk        (clk),
            .arst_n     (arst_n),
            .hard_flt_i (hard_flt[g]),
            .dsat_flt_i (dsat_flt[g]),
            .rise_i     (rise[g]),
            .rst_act_i  (rst_act),
            .unlatch_i  (unlatch),
            .state_o    (st[g])
         );

         assign flt_stat_o[g] = any_fault(st[g]);
         assign drv_en_o[g]   = cmd_i[g] & ~flt_stat_o[g] & ~rst_act;
      end
   endgenerate

endmodule

// File: rtl/ofl_ctrl_chk.sv
module ofl_ctrl_chk #(
   parameter int unsigned N_CH = 8,
   parameter logic [N_CH-1:0] GEN_MASK  = '0,
   parameter logic [N_CH-1:0] LAMP_MASK = '0
) (
   input logic            clk,
   input logic            arst_n,
   input logic [N_CH-1:0] cmd_i,
   input logic [N_CH-1:0] ocur_i,
   input logic [N_CH-1:0] therm_i,
   input logic            ce_n_i,
   input logic            rst_pin_n,
   input logic            lv_det_i,
   input logic [N_CH-1:0] drv_en_o,
   input logic [N_CH-1:0] flt_stat_o
);

   logic any_rst;
   assign any_rst = ~rst_pin_n | lv_det_i;

   // R1
   gen_latch_chk: assert property (@(posedge clk) disable iff (!arst_n)
      ((ocur_i & GEN_MASK) != '0) |=> ((flt_stat_o & $past(ocur_i & GEN_MASK)) == $past(ocur_i & GEN_MASK)));

   // R2
   lamp_latch_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (((ocur_i | therm_i) & LAMP_MASK) != '0) |=>
         ((flt_stat_o & $past((ocur_i | therm_i) & LAMP_MASK)) == $past((ocur_i | therm_i) & LAMP_MASK)));

   // R3
   no_drive_faulted_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (drv_en_o & flt_stat_o) == '0);

   // R3
   no_drive_uncmd_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (drv_en_o & ~cmd_i) == '0);

   // R6
   rst_forces_off_chk: assert property (@(posedge clk) disable iff (!arst_n)
      any_rst |-> (drv_en_o == '0));

   // R4
   generate
      for (genvar g = 0; g < N_CH; g++) begin : g_fall
         clear_cause_chk: assert property (@(posedge clk) disable iff (!arst_n)
            $fell(flt_stat_o[g]) |-> ($past(cmd_i[g]) || $past(any_rst) || !$past(ce_n_i)));
      end
   endgenerate

endmodule

bind ofl_ctrl ofl_ctrl_chk #(
   .N_CH      (N_CH),
   .GEN_MASK  (GEN_MASK),
   .LAMP_MASK (LAMP_MASK)
) u_chk (
   .clk        (clk),
   .arst_n     (arst_n),
   .cmd_i      (cmd_i),
   .ocur_i     (ocur_i),
   .therm_i    (therm_i),
   .ce_n_i     (ce_n_i),
   .rst_pin_n  (rst_pin_n),
   .lv_det_i   (lv_det_i),
   .drv_en_o   (drv_en_o),
   .flt_stat_o (flt_stat_o)
);

// File: tb/ofl_ctrl_tb.sv
module ofl_ctrl_tb;

   logic       clk = 1'b0;
   logic       arst_n;
   logic [7:0] cmd_i, ocur_i, therm_i, desat_i;
   logic       ce_n_i, rst_pin_n, lv_det_i;
   logic [7:0] drv_en_o, flt_stat_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   ofl_ctrl u_dut (
      .clk        (clk),
      .arst_n     (arst_n),
      .cmd_i      (cmd_i),
      .ocur_i     (ocur_i),
      .therm_i    (therm_i),
      .desat_i    (desat_i),
      .ce_n_i     (ce_n_i),
      .rst_pin_n  (rst_pin_n),
      .lv_det_i   (lv_det_i),
      .drv_en_o   (drv_en_o),
      .flt_stat_o (flt_stat_o)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic clear_ch(input logic [7:0] m);
      cmd_i = 8'hFF & ~m; step();
      cmd_i = 8'hFF;      step();
   endtask

   task automatic t_reset_state();
      chk("R10", "status in reset", flt_stat_o, 8'h00);
      chk("R10", "drive in reset",  drv_en_o,   8'h00);
      arst_n = 1'b1; step();
   endtask

   task automatic t_general();
      cmd_i = 8'hFF; step();
      chk("R3", "drive all on", drv_en_o, 8'hFF);
      ocur_i = 8'h08; step(); ocur_i = 8'h00;
      chk("R1", "ch3 over-current latched", flt_stat_o, 8'h08);
      chk("R11", "bit3 only", flt_stat_o & 8'h08, 8'h08);
      chk("R3", "ch3 gated off", drv_en_o, 8'hF7);
      therm_i = 8'h3F; step(); therm_i = 8'h00;
      chk("R1", "thermal ignored on general", flt_stat_o, 8'h08);
   endtask

   task automatic t_clear();
      step(); step(); step();
      chk("R4", "held with command high", flt_stat_o, 8'h08);
      cmd_i = 8'hF7; step();
      chk("R4", "held with command low", flt_stat_o, 8'h08);
      cmd_i = 8'hFF; #1;
      chk("R4", "drive still off before edge", drv_en_o, 8'hF7);
      step();
      chk("R4", "cleared after rising command", flt_stat_o, 8'h00);
      chk("R3", "drive restored", drv_en_o, 8'hFF);
   endtask

   task automatic t_persist();
      ocur_i = 8'h01; step();
      cmd_i = 8'hFE; step();
      cmd_i = 8'hFF; step();
      chk("R5", "fault wins over clear edge", flt_stat_o, 8'h01);
      ocur_i = 8'h00; step();
      chk("R5", "no clear without new edge", flt_stat_o, 8'h01);
      clear_ch(8'h01);
      chk("R4", "second clear releases", flt_stat_o, 8'h00);
   endtask

   task automatic t_lamp();
      therm_i = 8'h80; step(); therm_i = 8'h00;
      chk("R2", "ch7 thermal latched", flt_stat_o, 8'h80);
      ocur_i = 8'h40; step(); ocur_i = 8'h00;
      chk("R2", "ch6 current limit latched", flt_stat_o, 8'hC0);
      clear_ch(8'hC0);
      chk("R2", "lamp channels cleared", flt_stat_o, 8'h00);
   endtask

   task automatic t_pin_reset();
      ocur_i = 8'h16; step(); ocur_i = 8'h00;
      chk("R1", "ch1 ch2 ch4 latched", flt_stat_o, 8'h16);
      rst_pin_n = 1'b0; #1;
      chk("R6", "pin reset forces off", drv_en_o, 8'h00);
      step(); rst_pin_n = 1'b1; #1;
      chk("R7", "only ch1 ch2 cleared", flt_stat_o, 8'h10);
      chk("R3", "drive after reset", drv_en_o, 8'hEF);
      rst_pin_n = 1'b0; ocur_i = 8'h02; step();
      rst_pin_n = 1'b1; ocur_i = 8'h00;
      chk("R7", "fault wins over reset clear", flt_stat_o, 8'h12);
      clear_ch(8'h12);
      chk("R4", "cleared after reset test", flt_stat_o, 8'h00);
   endtask

   task automatic t_lvd();
      ocur_i = 8'h26; step(); ocur_i = 8'h00;
      lv_det_i = 1'b1; #1;
      chk("R8", "low supply forces off", drv_en_o, 8'h00);
      step(); lv_det_i = 1'b0; #1;
      chk("R8", "low supply clears ch1 ch2 only", flt_stat_o, 8'h20);
      clear_ch(8'h20);
   endtask

   task automatic t_desat();
      desat_i = 8'h20; ocur_i = 8'h01; step();
      desat_i = 8'h00; ocur_i = 8'h00;
      chk("R9", "desat and hard latched", flt_stat_o, 8'h21);
      step();
      chk("R9", "held with select high", flt_stat_o, 8'h21);
      ce_n_i = 1'b0; step(); ce_n_i = 1'b1;
      chk("R9", "select low frees desat only", flt_stat_o, 8'h01);
      desat_i = 8'h20; ce_n_i = 1'b0; step();
      chk("R9", "present desat wins over unlatch", flt_stat_o, 8'h21);
      desat_i = 8'h00; step(); ce_n_i = 1'b1;
      chk("R9", "desat released later", flt_stat_o, 8'h01);
      clear_ch(8'h01);
      chk("R4", "all clear at end", flt_stat_o, 8'h00);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      arst_n = 1'b0; cmd_i = 8'h00; ocur_i = 8'h00; therm_i = 8'h00;
      desat_i = 8'h00; ce_n_i = 1'b1; rst_pin_n = 1'b1; lv_det_i = 1'b0;
      repeat (3) @(negedge clk);
      t_reset_state();
      t_general();
      t_clear();
      t_persist();
      t_lamp();
      t_pin_reset();
      t_lvd();
      t_desat();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

endmodule